// File: doc/BRIEF.md
# Control Order Decode Sequencer

This block runs the control cycle of a disk file controller. A one-cycle `start` pulse begins a cycle. The block then pulls characters from a channel write bus one at a time. For each character it raises a service request and waits for the channel's response. A digit counter moves forward only when a character has been accepted, so a slow channel stretches the cycle but never corrupts it.

The first order character picks the class of the cycle:

- **Short class.** Only the second order character follows. It selects a mode change or a no-op, and the cycle ends at digit 3.
- **Long class.** The second character selects a file operation. Eight address characters follow. They fill the access, module, track and record fields, and the cycle ends at digit 11.

Along the way the block does the following:

- It checks every character for odd parity.
- It reports an order it does not recognise.
- It drives a select strobe and a ready-monitor level, which stand in for the drive-side actions.
- It ends each cycle with exactly one status pulse: normal end or unusual end.

Top module: `ctl_order_seq`

## Requirements
- R1: After reset, all of the following are 0: `busy`, `svc_req`, `end_ok`, `end_err`, `sel_stb`, `mon_armed`, `op_flags`, `bit_mode` and every address field.
- R2: For each character, `svc_req` is raised and held high until the cycle in which `svc_ack` is high. That character is taken from `wr_char`/`wr_par` in that cycle. While no response arrives, the cycle does not advance.
- R3: A character is valid when `wr_char` together with `wr_par` has an odd number of ones. A parity error ends the cycle with `end_err`, and no further character is requested.
- R4: First character 0 selects the short class: exactly 2 characters are taken, then `end_ok`. First character 8 selects the long class: exactly 10 characters are taken, then `end_ok`. Exactly one end pulse is given per cycle.
- R5: Any other first character, or an unknown second character, is an invalid order. The cycle then ends with `end_err` at digit 3. That means 2 characters for short or bad-class orders, and 3 characters for the long class (the third is not stored).
- R6: In a long cycle, characters 3 to 10 (1-based) are stored in this order: access, module, four track characters, two record characters. In the packed track and record outputs, the earlier character is the more significant.
- R7: Every long cycle clears all address fields once its second character is accepted. If a later parity error ends the cycle, only the characters before the failing one remain stored.
- R8: `bit_mode` is set by short code 1 (release) and short code 2 (six-bit). It is cleared by short code 3 (eight-bit). Nothing else changes it.
- R9: `op_flags` bit meanings:
  - bit0 is no-op, set by short code 0 or long code 0.
  - bits 1, 2 and 3 are seek, write check and set-inoperative, set by long codes 1, 2 and 3.
  - bits 4 to 7 are the prepare-to-verify variants, set by long codes 4 to 7.

  Flag clearing rules:
  - bit0 is cleared when a cycle starts.
  - All flags are cleared when the second character is accepted, unless the order is long write check, in which case they are kept.
  - bits 1 and 3 are cleared at every cycle end.
- R10: A long cycle with a valid order pulses `sel_stb` once, at digit 5, after the 5th character has been accepted. No other cycle pulses it.
- R11: `mon_armed` goes high at digit 9 of a valid long cycle, unless the order is set-inoperative. It stays high until that cycle ends and is never high outside a long cycle.
- R12: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a control cycle (ignored while busy) |
| svc_ack | input | 1 | Channel response: character present this cycle |
| wr_char | input | CW | Character from the write bus |
| wr_par | input | 1 | Parity bit of the character (odd parity) |
| svc_req | output | 1 | Service request for the next character |
| busy | output | 1 | A control cycle is running |
| end_ok | output | 1 | One-cycle normal end pulse |
| end_err | output | 1 | One-cycle unusual end pulse |
| sel_stb | output | 1 | Drive select strobe at digit 5 of a long cycle |
| mon_armed | output | 1 | Ready/operative monitor armed |
| op_flags | output | 8 | Control-op flags |
| bit_mode | output | 1 | 1 = six-bit mode, 0 = eight-bit mode |
| acc_q | output | CW | Access field |
| mod_q | output | CW | Module field |
| trk_q | output | TRK_N*CW | Track field |
| rec_q | output | REC_N*CW | Record field |

## Verification
The hardest situations to reach are a parity error deep inside a long cycle that follows an earlier cycle with a different address, and a write-check order that follows a prepare-to-verify order. Only these show that the address clear and the flag retention work. Directed sequences set up such pairs deliberately. Random orders then mix classes, codes, parity-fault positions and response delays. Each response delay keeps `svc_req` waiting for several cycles, and the bench checks that it stays high throughout.

// File: rtl/ctl_order_pkg.sv
package ctl_order_pkg;
  localparam int NOPS   = 8;
  localparam int OPB_NOOP  = 0;
  localparam int OPB_SEEK  = 1;
  localparam int OPB_WRCHK = 2;
  localparam int OPB_SINOP = 3;
  localparam int OPB_PTV0  = 4;

  localparam int FIRST_SHORT = 0;
  localparam int FIRST_LONG  = 8;

  localparam int SC_NOOP  = 0;
  localparam int SC_REL   = 1;
  localparam int SC_SIX   = 2;
  localparam int SC_EIGHT = 3;
  localparam int SC_COUNT = 4;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_LONG  = 2'd2,
    CLS_BAD   = 2'd3
  } ord_cls_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_LOAD  = 2'd2,
    ST_FINAL = 2'd3
  } seq_st_t;
endpackage

// File: rtl/ctl_par_chk.sv
module ctl_par_chk #(
  parameter int W = 6
) (
  input  logic [W-1:0] data,
  input  logic         par,
  output logic         bad
);
  // odd parity: total ones over data and parity bit must be odd
  assign bad = ~(^{par, data});
endmodule

// File: rtl/ctl_order_dec.sv
module ctl_order_dec
  import ctl_order_pkg::*;
#(
  parameter int CW = 6
) (
  input  ord_cls_t        cls,
  input  logic [CW-1:0]   code,
  output logic            valid,
  output logic [NOPS-1:0] onehot,
  output logic            bm_set,
  output logic            bm_clr,
  output logic            keep_flags,
  output logic            is_sinop
);
  localparam logic [CW-1:0] LONG_LIM  = CW'(NOPS);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SC_COUNT);

  always_comb begin
    valid      = 1'b0;
    onehot     = '0;
    bm_set     = 1'b0;
    bm_clr     = 1'b0;
    keep_flags = 1'b0;
    is_sinop   = 1'b0;
    unique case (cls)
      CLS_LONG: begin
        if (code < LONG_LIM) begin
          valid = 1'b1;
          for (int i = 0; i < NOPS; i++) begin
            onehot[i] = (code == CW'(i));
          end
        end
        keep_flags = (code == CW'(OPB_WRCHK));
        is_sinop   = (code == CW'(OPB_SINOP));
      end
      CLS_SHORT: begin
        if (code < SHORT_LIM) begin
          valid = 1'b1;
          onehot[OPB_NOOP] = (code == CW'(SC_NOOP));
          bm_set = (code == CW'(SC_REL)) || (code == CW'(SC_SIX));
          bm_clr = (code == CW'(SC_EIGHT));
        end
      end
      default: begin
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ctl_addr_store.sv
module ctl_addr_store #(
  parameter int CW    = 6,
  parameter int TRK_N = 4,
  parameter int REC_N = 2,
  localparam int NSLOT = 2 + TRK_N + REC_N,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [SW-1:0]      idx,
  input  logic [CW-1:0]      din,
  output logic [CW-1:0]      acc_q,
  output logic [CW-1:0]      mod_q,
  output logic [TRK_N*CW-1:0] trk_q,
  output logic [REC_N*CW-1:0] rec_q
);
  logic [CW-1:0] slot [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slot[s] <= '0;
      end else if (wr_en && (idx == SW'(s))) begin
        slot[s] <= din;
      end
    end
  end

  assign acc_q = slot[0];
  assign mod_q = slot[1];

  for (genvar t = 0; t < TRK_N; t++) begin : g_trk
    assign trk_q[(TRK_N-1-t)*CW +: CW] = slot[2+t];
  end

  for (genvar r = 0; r < REC_N; r++) begin : g_rec
    assign rec_q[(REC_N-1-r)*CW +: CW] = slot[2+TRK_N+r];
  end
endmodule

// File: rtl/ctl_order_seq.sv
module ctl_order_seq
  import ctl_order_pkg::*;
#(
  parameter int CW    = 6,
  parameter int TRK_N = 4,
  parameter int REC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 svc_ack,
  input  logic [CW-1:0]        wr_char,
  input  logic                 wr_par,
  output logic                 svc_req,
  output logic                 busy,
  output logic                 end_ok,
  output logic                 end_err,
  output logic                 sel_stb,
  output logic                 mon_armed,
  output logic [NOPS-1:0]      op_flags,
  output logic                 bit_mode,
  output logic [CW-1:0]        acc_q,
  output logic [CW-1:0]        mod_q,
  output logic [TRK_N*CW-1:0]  trk_q,
  output logic [REC_N*CW-1:0]  rec_q
);
  localparam int NSLOT     = 2 + TRK_N + REC_N;
  localparam int SW        = $clog2(NSLOT);
  localparam int ADDR_DIG0 = 3;
  localparam int LAST_DIG  = ADDR_DIG0 + NSLOT - 1;
  localparam int END_LONG  = LAST_DIG + 1;
  localparam int END_SHORT = 3;
  localparam int SEL_DIG   = 5;
  localparam int MON_DIG   = LAST_DIG - 1;
  localparam int DW        = $clog2(END_LONG + 1);

  seq_st_t        st;
  logic [DW-1:0]  dg;
  logic [CW-1:0]  ser;
  logic           ser_bad;
  ord_cls_t       cls;
  logic           inv;
  logic           sinop_q;

  logic            par_bad;
  logic            dec_valid;
  logic [NOPS-1:0] dec_onehot;
  logic            dec_bm_set;
  logic            dec_bm_clr;
  logic            dec_keep;
  logic            dec_sinop;

  ctl_par_chk #(.W(CW)) u_par (
    .data (wr_char),
    .par  (wr_par),
    .bad  (par_bad)
  );

  ctl_order_dec #(.CW(CW)) u_dec (
    .cls        (cls),
    .code       (ser),
    .valid      (dec_valid),
    .onehot     (dec_onehot),
    .bm_set     (dec_bm_set),
    .bm_clr     (dec_bm_clr),
    .keep_flags (dec_keep),
    .is_sinop   (dec_sinop)
  );

  logic          in_load_ok;
  logic          addr_clr;
  logic          addr_wr;
  logic [SW-1:0] addr_idx;
  logic          addr_digit;

  assign in_load_ok = (st == ST_LOAD) && !ser_bad;
  assign addr_digit = (dg >= DW'(ADDR_DIG0)) && (dg <= DW'(LAST_DIG));
  assign addr_clr   = in_load_ok && (dg == DW'(2)) && (cls == CLS_LONG);
  assign addr_wr    = in_load_ok && addr_digit &&
                      !((dg == DW'(ADDR_DIG0)) && inv);
  assign addr_idx   = SW'(dg - DW'(ADDR_DIG0));

  ctl_addr_store #(.CW(CW), .TRK_N(TRK_N), .REC_N(REC_N)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .clr   (addr_clr),
    .wr_en (addr_wr),
    .idx   (addr_idx),
    .din   (ser),
    .acc_q (acc_q),
    .mod_q (mod_q),
    .trk_q (trk_q),
    .rec_q (rec_q)
  );

  // first order character classification
  function automatic ord_cls_t classify(input logic [CW-1:0] c);
    if (c == CW'(FIRST_SHORT))     return CLS_SHORT;
    else if (c == CW'(FIRST_LONG)) return CLS_LONG;
    else                           return CLS_BAD;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      dg        <= '0;
      ser       <= '0;
      ser_bad   <= 1'b0;
      cls       <= CLS_NONE;
      inv       <= 1'b0;
      sinop_q   <= 1'b0;
      svc_req   <= 1'b0;
      busy      <= 1'b0;
      end_ok    <= 1'b0;
      end_err   <= 1'b0;
      sel_stb   <= 1'b0;
      mon_armed <= 1'b0;
      op_flags  <= '0;
      bit_mode  <= 1'b0;
    end else begin
      end_ok  <= 1'b0;
      end_err <= 1'b0;
      sel_stb <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            busy               <= 1'b1;
            dg                 <= '0;
            cls                <= CLS_NONE;
            inv                <= 1'b0;
            sinop_q            <= 1'b0;
            op_flags[OPB_NOOP] <= 1'b0;
            svc_req            <= 1'b1;
            st                 <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (svc_ack) begin
            ser     <= wr_char;
            ser_bad <= par_bad;
            dg      <= dg + DW'(1);
            svc_req <= 1'b0;
            st      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ser_bad) begin
            end_err            <= 1'b1;
            busy               <= 1'b0;
            mon_armed          <= 1'b0;
            op_flags[OPB_SEEK]  <= 1'b0;
            op_flags[OPB_SINOP] <= 1'b0;
            st                 <= ST_IDLE;
          end else if (dg == DW'(1)) begin
            cls     <= classify(ser);
            svc_req <= 1'b1;
            st      <= ST_REQ;
          end else if (dg == DW'(2)) begin
            op_flags <= (dec_keep ? op_flags : '0) | dec_onehot;
            if (dec_bm_set)      bit_mode <= 1'b1;
            else if (dec_bm_clr) bit_mode <= 1'b0;
            inv     <= !dec_valid;
            sinop_q <= dec_sinop;
            if (cls == CLS_LONG) begin
              svc_req <= 1'b1;
              st      <= ST_REQ;
            end else begin
              dg <= DW'(END_SHORT);
              st <= ST_FINAL;
            end
          end else if ((dg == DW'(ADDR_DIG0)) && inv) begin
            end_err            <= 1'b1;
            busy               <= 1'b0;
            op_flags[OPB_SEEK]  <= 1'b0;
            op_flags[OPB_SINOP] <= 1'b0;
            st                 <= ST_IDLE;
          end else begin
            if (dg == DW'(SEL_DIG)) sel_stb <= 1'b1;
            if ((dg == DW'(MON_DIG)) && !sinop_q && !inv) mon_armed <= 1'b1;
            if (dg == DW'(LAST_DIG)) begin
              dg <= DW'(END_LONG);
              st <= ST_FINAL;
            end else begin
              svc_req <= 1'b1;
              st      <= ST_REQ;
            end
          end
        end
        ST_FINAL: begin
          end_ok             <= !inv;
          end_err            <= inv;
          busy               <= 1'b0;
          mon_armed          <= 1'b0;
          op_flags[OPB_SEEK]  <= 1'b0;
          op_flags[OPB_SINOP] <= 1'b0;
          st                 <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctl_order_seq_chk.sv
module ctl_order_seq_chk #(
  parameter int CW    = 6,
  parameter int TRK_N = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              svc_req,
  input logic              svc_ack,
  input logic              busy,
  input logic              end_ok,
  input logic              end_err,
  input logic              sel_stb,
  input logic              mon_armed,
  input logic              bit_mode,
  input logic [TRK_N*CW-1:0] trk_q
);
  p_end_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(end_ok && end_err));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (svc_req && !svc_ack) |=> svc_req);

  p_req_busy_r2: assert property (@(posedge clk) disable iff (rst)
    svc_req |-> busy);

  p_end_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (end_ok || end_err) |-> !busy);

  p_sel_mid_r10: assert property (@(posedge clk) disable iff (rst)
    sel_stb |-> (busy && !end_ok && !end_err));

  p_mon_busy_r11: assert property (@(posedge clk) disable iff (rst)
    mon_armed |-> busy);

  p_bm_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(bit_mode));

  p_addr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(trk_q));
endmodule

bind ctl_order_seq ctl_order_seq_chk #(.CW(CW), .TRK_N(TRK_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .svc_req   (svc_req),
  .svc_ack   (svc_ack),
  .busy      (busy),
  .end_ok    (end_ok),
  .end_err   (end_err),
  .sel_stb   (sel_stb),
  .mon_armed (mon_armed),
  .bit_mode  (bit_mode),
  .trk_q     (trk_q)
);

// File: tb/sim_ctl_order_seq.sv
module sim_ctl_order_seq;
  localparam int CW = 6;
  localparam int TRK_N = 4;
  localparam int REC_N = 2;

  logic clk = 1'b0;
  logic rst, start, svc_ack, wr_par;
  logic [CW-1:0] wr_char;
  logic svc_req, busy, end_ok, end_err, sel_stb, mon_armed, bit_mode;
  logic [7:0] op_flags;
  logic [CW-1:0] acc_q, mod_q;
  logic [TRK_N*CW-1:0] trk_q;
  logic [REC_N*CW-1:0] rec_q;

  always #10 clk = ~clk;

  ctl_order_seq #(.CW(CW), .TRK_N(TRK_N), .REC_N(REC_N)) u0 (
    .clk(clk), .rst(rst), .start(start), .svc_ack(svc_ack),
    .wr_char(wr_char), .wr_par(wr_par), .svc_req(svc_req), .busy(busy),
    .end_ok(end_ok), .end_err(end_err), .sel_stb(sel_stb),
    .mon_armed(mon_armed), .op_flags(op_flags), .bit_mode(bit_mode),
    .acc_q(acc_q), .mod_q(mod_q), .trk_q(trk_q), .rec_q(rec_q)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]          m_flags = '0;
  logic                m_bm = 1'b0;
  logic [CW-1:0]       m_slot [8];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Model of one cycle from the requirements
  task automatic model(input logic [5:0] c[10], input int badp,
                       output int n, output bit ok,
                       output bit sel, output bit mon);
    int cls;  // 0 short, 1 long, 2 bad
    bit valid;
    logic [7:0] oh;
    sel = 0; mon = 0; ok = 0;
    m_flags[0] = 1'b0;                                  // R9 cleared at start
    if (badp == 0) begin n = 1; m_flags[1] = 0; m_flags[3] = 0; return; end
    cls = (c[0] == 6'd0) ? 0 : (c[0] == 6'd8) ? 1 : 2;  // R4 R5
    if (badp == 1) begin n = 2; m_flags[1] = 0; m_flags[3] = 0; return; end
    valid = 0; oh = '0;
    if (cls == 1 && c[1] < 8) begin valid = 1; oh = 8'd1 << c[1]; end
    if (cls == 0 && c[1] < 4) begin
      valid = 1;
      if (c[1] == 0) oh = 8'd1;
      if (c[1] == 1 || c[1] == 2) m_bm = 1'b1;          // R8
      if (c[1] == 3) m_bm = 1'b0;
    end
    if (!(cls == 1 && c[1] == 6'd2)) m_flags = '0;      // R9 retention
    m_flags |= oh;
    if (cls == 1) for (int i = 0; i < 8; i++) m_slot[i] = '0;  // R7
    if (cls != 1) begin
      n = 2; ok = valid && (cls == 0);
    end else if (badp == 2 || !valid) begin
      n = 3; ok = 0;
    end else begin
      n = 10; ok = 1;
      for (int i = 2; i < 10; i++) begin
        if (badp == i) begin n = i + 1; ok = 0; break; end
        m_slot[i-2] = c[i];
        if (i == 4) sel = 1;
        if (i == 8 && c[1] != 6'd3) mon = 1;
      end
    end
    m_flags[1] = 0; m_flags[3] = 0;
  endtask

  task automatic run(input string tag, input logic [5:0] c[10],
                     input int badp, input bit extra_start);
    int n = 0, dly = 0, cyc = 0, sels = 0, sel_at = -1;
    int en; bit eok, esel, emon;
    bit mon_seen = 0, got_ok = 0, got_err = 0, done = 0, waiting = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) begin
      svc_ack = 1'b0;
      start = (extra_start && cyc == 3);
      if (waiting) chk("R2", {tag, " req held"}, svc_req, 1'b1);
      waiting = 0;
      if (sel_stb) begin sels++; sel_at = n; end
      if (mon_armed) mon_seen = 1;
      if (end_ok || end_err) begin
        got_ok = end_ok; got_err = end_err; done = 1;
      end else if (svc_req) begin
        if (dly > 0) begin dly--; waiting = 1; end
        else if (n < 10) begin
          svc_ack = 1'b1;
          wr_char = c[n];
          wr_par = ~(^c[n]) ^ (n == badp);
          n++;
          dly = $urandom % 4;
        end
      end
      cyc++;
      if (cyc > 400) begin
        errors++; checks++;
        $display("FAIL R2 %s: cycle hung, actual no end expected end", tag);
        done = 1;
      end
      if (!done) @(negedge clk);
    end
    start = 1'b0;
    model(c, badp, en, eok, esel, emon);
    chk("R4", {tag, " chars taken"}, n, en);
    chk(badp >= 0 ? "R3" : "R5", {tag, " end_ok"}, got_ok, eok);
    chk("R4", {tag, " end_err"}, got_err, !eok);
    chk("R10", {tag, " sel count"}, sels, esel ? 1 : 0);
    if (esel) chk("R10", {tag, " sel after chars"}, sel_at, 5);
    chk("R11", {tag, " mon"}, mon_seen, emon);
    chk("R9", {tag, " flags"}, op_flags, m_flags);
    chk("R8", {tag, " bit_mode"}, bit_mode, m_bm);
    chk("R6", {tag, " acc"}, acc_q, m_slot[0]);
    chk("R6", {tag, " mod"}, mod_q, m_slot[1]);
    chk("R7", {tag, " trk"}, trk_q, {m_slot[2], m_slot[3], m_slot[4], m_slot[5]});
    chk("R6", {tag, " rec"}, rec_q, {m_slot[6], m_slot[7]});
    @(negedge clk);
    chk("R12", {tag, " idle after end"}, busy, 1'b0);
  endtask

  task automatic fill(output logic [5:0] c[10], input logic [5:0] a, input logic [5:0] b);
    c[0] = a; c[1] = b;
    for (int i = 2; i < 10; i++) c[i] = 6'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] c[10];
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_slot[i] = '0;
    rst = 1'b1; start = 1'b0; svc_ack = 1'b0; wr_char = '0; wr_par = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "svc_req", svc_req, 0);
    chk("R1", "ends", {end_ok, end_err, sel_stb, mon_armed}, 0);
    chk("R1", "flags", op_flags, 0);
    chk("R1", "bit_mode", bit_mode, 0);
    chk("R1", "addr", {acc_q, mod_q, trk_q, rec_q}, 0);

    fill(c, 0, 0); run("short noop", c, -1, 0);
    fill(c, 0, 2); run("six bit", c, -1, 0);
    fill(c, 0, 3); run("eight bit", c, -1, 0);
    fill(c, 0, 1); run("release", c, -1, 0);
    fill(c, 8, 1); run("long seek", c, -1, 0);
    fill(c, 8, 4); run("ptv0", c, -1, 0);
    fill(c, 8, 2); run("wrchk keep", c, -1, 0);
    fill(c, 8, 3); run("set inop", c, -1, 0);
    fill(c, 5, 0); run("bad class", c, -1, 0);
    fill(c, 0, 9); run("bad short code", c, -1, 0);
    fill(c, 8, 12); run("bad long code", c, -1, 0);
    fill(c, 8, 1); run("long full", c, -1, 0);
    fill(c, 8, 5); run("par mid long", c, 5, 0);
    fill(c, 8, 6); run("par first", c, 0, 0);
    fill(c, 0, 2); run("par second", c, 1, 0);
    fill(c, 8, 7); run("start busy", c, -1, 1);

    for (int k = 0; k < 60; k++) begin
      int sel = $urandom % 3;
      logic [5:0] a = (sel == 0) ? 6'd0 : (sel == 1) ? 6'd8 : 6'($urandom);
      int bp = ($urandom % 4 == 0) ? int'($urandom % 10) : -1;
      fill(c, a, 6'($urandom % 10));
      run("random", c, bp, ($urandom % 5) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule